// File: doc/BRIEF.md
# SPI Master Frame Shifter

This block moves one serial data frame in and out as the clocking side of an SPI link. A single-cycle start pulse captures a 32-bit transmit word together with the frame configuration. The block then produces the serial clock from the system clock, drives the transmit bits on the data-out pin and collects the bits that arrive on the data-in pin. When the last clock edge of the frame has passed, it presents the received word and raises a one-cycle completion pulse.

The frame length is set by a 4-bit code and runs from 4 to 32 bits. Either end of the word can go first. The serial clock rate, its idle level and the edge on which data is sampled are all programmable. An optional parity bit can be appended after the data bits in both directions, and the received parity is checked unless the frame is transmit-only. Selecting and timing the slave, and any buffering or register access, belong to the surrounding logic.

Top module: `spim_frame_master`

## Requirements
- R1: The frame length code `len_code` selects the number of data bits. Codes 0 to 12 give 4 to 16 bits in steps of one, 13 gives 20 bits, 14 gives 24 and 15 gives 32. A frame of N serial bits (data plus optional parity) has exactly 2N SCK edges.
- R2: With `lsb_first` = 0 the data bits go out and come in most significant bit first. With `lsb_first` = 1 the least significant bit goes first. Bits of `tx_word` above the frame length are never transmitted.
- R3: Each SCK level lasts 2^`div_sel` system clock cycles, so one full SCK period is 2^(`div_sel`+1) cycles (a divide ratio of 2 to 256). `done` is seen 2N·2^`div_sel` cycles after the cycle in which the start is accepted.
- R4: While no frame is running, `sck` follows `cpol` one cycle later: 0 gives a low idle level and 1 gives a high one. At the end of a frame, `sck` is back at the captured idle level.
- R5: With `cpha` = 0, the first bit is on `mosi` before the first edge, `miso` is sampled on the odd edges (1, 3, …) and `mosi` changes on the even edges other than the last. With `cpha` = 1, `mosi` changes on the odd edges and `miso` is sampled on the even edges.
- R6: With `par_en` = 1, one parity bit follows the data bits in both directions. With `par_odd` = 0 the parity is even, meaning the XOR of the data bits and the parity bit is 0. With `par_odd` = 1 the parity is odd, and that XOR is 1.
- R7: A received parity bit that disagrees with the received data sets `perr`. The flag stays set until `perr_clr` is high at a clock edge. When a mismatch and a clear fall on the same edge, the flag ends up set.
- R8: With `tx_only` = 1 the received parity is not checked and `perr` is not set, even with parity enabled.
- R9: `done` is high for exactly one cycle. In that same cycle `rx_word` takes the received data right-aligned, with every bit above the frame length at zero. `rx_word` then holds until the next frame completes.
- R10: A start pulse during a running frame is ignored. All configuration inputs and `tx_word` are captured only when a start is accepted, and changes to them during a frame have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame (accepted only when idle) |
| tx_word | input | 32 | Word to transmit, right-aligned |
| len_code | input | 4 | Frame length code |
| lsb_first | input | 1 | 1: least significant bit first |
| div_sel | input | 3 | SCK divider select, ratio 2^(div_sel+1) |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | 0: sample on odd edges; 1: sample on even edges |
| par_en | input | 1 | Append and expect a parity bit |
| par_odd | input | 1 | 0: even parity; 1: odd parity |
| tx_only | input | 1 | Skip the receive parity check |
| perr_clr | input | 1 | Clear the parity error flag |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| rx_word | output | 32 | Last received word, right-aligned |
| done | output | 1 | One-cycle frame completion pulse |
| perr | output | 1 | Sticky receive parity error |

## Verification
A wrong edge counter or divider count shows up on `sck` within one SCK half-period, and it moves `done` away from its expected cycle. A wrong transmit bit pointer or bad pre-alignment shows on `mosi` at the first drive edge after the fault. Receive-side faults, such as a shift in the wrong direction, a missed sample or a parity slot filled from a data bit, stay hidden until the completion cycle. There they appear on `rx_word` and `perr`. The bench therefore compares every output against a behavioural model on every clock, and it also checks the frame duration and the received word against values derived directly from the requirements.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int DATA_W = 32;
    localparam int CODE_W = 4;
    localparam int DIV_W  = 3;
    localparam int LEN_W  = $clog2(DATA_W + 1);
    localparam int EDGE_W = LEN_W + 2;
    localparam int HALF_W = (1 << DIV_W) - 1;

    typedef struct packed {
        logic [LEN_W-1:0] nbits;
        logic             lsb;
        logic             cpol;
        logic             cpha;
        logic [DIV_W-1:0] div;
        logic             pen;
        logic             podd;
        logic             txo;
    } spim_cfg_t;

    typedef struct packed {
        logic              active;
        spim_cfg_t         cfg;
        logic [EDGE_W-1:0] edge_cnt;
        logic [LEN_W-1:0]  tx_cnt;
        logic [LEN_W-1:0]  rx_cnt;
        logic [DATA_W-1:0] tx_sh;
        logic [DATA_W-1:0] rx_sh;
        logic              tx_par;
        logic              rx_par;
        logic              sck;
        logic              mosi;
        logic              done;
        logic              perr;
        logic [DATA_W-1:0] rx_word;
    } spim_state_t;

endpackage

// File: rtl/spim_len_dec.sv
module spim_len_dec #(
    parameter int CODE_W = 4,
    parameter int LEN_W  = 6
) (
    input  logic [CODE_W-1:0] code,
    output logic [LEN_W-1:0]  nbits
);

    always_comb begin
        case (code)
            CODE_W'(13): nbits = LEN_W'(20);
            CODE_W'(14): nbits = LEN_W'(24);
            CODE_W'(15): nbits = LEN_W'(32);
            default:     nbits = LEN_W'(code) + LEN_W'(4);
        endcase
    end

endmodule

// File: rtl/spim_tick_gen.sv
module spim_tick_gen #(
    parameter int DIV_W  = 3,
    parameter int HALF_W = (1 << DIV_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);

    logic [HALF_W-1:0] cnt_d, cnt_q, lim;

    always_comb begin
        lim   = {HALF_W{1'b1}} >> (HALF_W - int'(div_sel));
        tick  = run && (cnt_q == lim);
        cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3: the half-period count never passes the selected limit
    assert_half_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim);

    // R3: the count restarts from zero whenever no frame is running
    assert_idle_rewind_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);

endmodule

// File: rtl/spim_frame_master.sv
module spim_frame_master
    import spim_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_word,
    input  logic [CODE_W-1:0] len_code,
    input  logic              lsb_first,
    input  logic [DIV_W-1:0]  div_sel,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              tx_only,
    input  logic              perr_clr,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_word,
    output logic              done,
    output logic              perr
);

    spim_state_t s_d, s_q;
    logic [LEN_W-1:0] nbits_in;
    logic             tick;

    spim_len_dec #(.CODE_W(CODE_W), .LEN_W(LEN_W)) u_len (
        .code  (len_code),
        .nbits (nbits_in)
    );

    spim_tick_gen #(.DIV_W(DIV_W), .HALF_W(HALF_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (s_q.active),
        .div_sel (s_q.cfg.div),
        .tick    (tick)
    );

    logic [DATA_W-1:0] mask, aligned, data;
    logic [EDGE_W-1:0] k, total;
    logic [LEN_W:0]    fbits;
    logic              odd, smp, drv;

    always_comb begin
        s_d     = s_q;
        s_d.done = 1'b0;
        mask    = {DATA_W{1'b1}} >> (DATA_W - int'(nbits_in));
        aligned = lsb_first ? tx_word : (tx_word << (DATA_W - int'(nbits_in)));
        fbits   = {1'b0, s_q.cfg.nbits} + {{LEN_W{1'b0}}, s_q.cfg.pen};
        total   = {fbits, 1'b0};
        k       = s_q.edge_cnt + 1'b1;
        odd     = k[0];
        smp     = (odd != s_q.cfg.cpha);
        drv     = s_q.cfg.cpha ? (odd && (k != EDGE_W'(1))) : (!odd && (k != total));
        data    = '0;

        if (perr_clr) s_d.perr = 1'b0;

        if (!s_q.active) begin
            s_d.sck = cpol;
            if (start) begin
                s_d.active   = 1'b1;
                s_d.cfg      = '{nbits: nbits_in, lsb: lsb_first, cpol: cpol, cpha: cpha,
                                 div: div_sel, pen: par_en, podd: par_odd, txo: tx_only};
                s_d.edge_cnt = '0;
                s_d.rx_cnt   = '0;
                s_d.rx_sh    = '0;
                s_d.rx_par   = 1'b0;
                s_d.tx_par   = (^(tx_word & mask)) ^ par_odd;
                s_d.mosi     = lsb_first ? aligned[0] : aligned[DATA_W-1];
                s_d.tx_sh    = lsb_first ? (aligned >> 1) : (aligned << 1);
                s_d.tx_cnt   = LEN_W'(1);
            end
        end else if (tick) begin
            s_d.edge_cnt = k;
            s_d.sck      = ~s_q.sck;
            if (smp) begin
                if (s_q.rx_cnt < s_q.cfg.nbits)
                    s_d.rx_sh = s_q.cfg.lsb ? {miso, s_q.rx_sh[DATA_W-1:1]}
                                            : {s_q.rx_sh[DATA_W-2:0], miso};
                else
                    s_d.rx_par = miso;
                s_d.rx_cnt = s_q.rx_cnt + 1'b1;
            end
            if (drv) begin
                if (s_q.tx_cnt < s_q.cfg.nbits) begin
                    s_d.mosi  = s_q.cfg.lsb ? s_q.tx_sh[0] : s_q.tx_sh[DATA_W-1];
                    s_d.tx_sh = s_q.cfg.lsb ? (s_q.tx_sh >> 1) : (s_q.tx_sh << 1);
                end else begin
                    s_d.mosi  = s_q.tx_par;
                end
                s_d.tx_cnt = s_q.tx_cnt + 1'b1;
            end
            if (k == total) begin
                data = s_q.cfg.lsb ? (s_d.rx_sh >> (DATA_W - int'(s_q.cfg.nbits))) : s_d.rx_sh;
                s_d.active  = 1'b0;
                s_d.done    = 1'b1;
                s_d.rx_word = data;
                if (s_q.cfg.pen && !s_q.cfg.txo && (s_d.rx_par != ((^data) ^ s_q.cfg.podd)))
                    s_d.perr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sck     = s_q.sck;
    assign mosi    = s_q.mosi;
    assign rx_word = s_q.rx_word;
    assign done    = s_q.done;
    assign perr    = s_q.perr;

    // R9: completion is a single-cycle pulse
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: nothing above the frame length is ever reported
    assert_rx_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((rx_word >> s_q.cfg.nbits) == '0));

    // R4: after the last edge the clock rests at the captured idle level
    assert_sck_rest_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sck == s_q.cfg.cpol));

    // R10: the captured configuration holds while a frame runs
    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active ##1 s_q.active) |-> $stable(s_q.cfg));

    // R7: the error flag only drops through a clear
    assert_perr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (perr && !perr_clr) |=> perr);

    // R8: a transmit-only frame never raises the error flag
    assert_txonly_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && s_q.cfg.txo && !perr) |=> !perr);

endmodule

// File: tb/tb_spim_frame_master.sv
`timescale 1ns/1ps
module tb_spim_frame_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] tx_word = '0;
    logic [3:0]  len_code = '0;
    logic        lsb_first = 1'b0;
    logic [2:0]  div_sel = '0;
    logic        cpol = 1'b0;
    logic        cpha = 1'b0;
    logic        par_en = 1'b0;
    logic        par_odd = 1'b0;
    logic        tx_only = 1'b0;
    logic        perr_clr = 1'b0;
    logic        miso = 1'b0;
    logic        sck, mosi, done, perr;
    logic [31:0] rx_word;

    always #2 clk = ~clk;

    spim_frame_master dut (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word), .len_code(len_code),
        .lsb_first(lsb_first), .div_sel(div_sel), .cpol(cpol), .cpha(cpha),
        .par_en(par_en), .par_odd(par_odd), .tx_only(tx_only), .perr_clr(perr_clr),
        .miso(miso), .sck(sck), .mosi(mosi), .rx_word(rx_word), .done(done), .perr(perr)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic int len_of(input logic [3:0] code);
        if (code <= 4'd12) return int'(code) + 4;
        if (code == 4'd13) return 20;
        if (code == 4'd14) return 24;
        return 32;
    endfunction

    function automatic logic [31:0] mask_of(input int n);
        if (n >= 32) return 32'hFFFF_FFFF;
        return (32'h1 << n) - 32'h1;
    endfunction

    // ---------------- behavioural reference model ----------------
    bit          m_act, m_sck, m_mosi, m_done, m_perr;
    bit          m_cpha, m_lsb, m_pen, m_podd, m_txo;
    int          m_cnt, m_edge, m_tot, m_h, m_n, txptr, kk;
    logic [31:0] m_rx, val;
    bit          setp;
    bit          txq[$];
    bit          rxq[$];
    bit          rxsrc[$];
    bit          cmp_on = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0; m_sck = 0; m_mosi = 0; m_done = 0; m_perr = 0; m_rx = '0;
        end else begin
            setp = 0;
            m_done = 0;
            if (!m_act) begin
                m_sck = cpol;
                if (start) begin
                    m_n = len_of(len_code);
                    m_lsb = lsb_first; m_cpha = cpha; m_pen = par_en; m_podd = par_odd; m_txo = tx_only;
                    m_h = 1 << div_sel;
                    m_tot = 2 * (m_n + (par_en ? 1 : 0));
                    txq.delete();
                    for (int i = 0; i < m_n; i++)
                        txq.push_back(lsb_first ? tx_word[i] : tx_word[m_n-1-i]);
                    if (par_en) txq.push_back((^(tx_word & mask_of(m_n))) ^ par_odd);
                    rxq.delete();
                    m_mosi = txq[0];
                    txptr = 1;
                    m_cnt = 0; m_edge = 0; m_act = 1;
                end
            end else if (m_cnt == m_h - 1) begin
                m_cnt = 0;
                m_edge++;
                kk = m_edge;
                m_sck = ~m_sck;
                if ((kk % 2 == 1) != m_cpha) rxq.push_back(miso);
                if (m_cpha ? (kk % 2 == 1 && kk > 1) : (kk % 2 == 0 && kk < m_tot)) begin
                    m_mosi = txq[txptr];
                    txptr++;
                end
                if (kk == m_tot) begin
                    val = '0;
                    for (int i = 0; i < m_n; i++) begin
                        if (m_lsb) val[i] = rxq[i];
                        else       val = {val[30:0], rxq[i]};
                    end
                    m_rx = val;
                    if (m_pen && !m_txo && (rxq[m_n] != ((^val) ^ m_podd))) setp = 1;
                    m_done = 1;
                    m_act = 0;
                end
            end else begin
                m_cnt++;
            end
            if (perr_clr) m_perr = 0;
            if (setp) m_perr = 1;
        end
    end

    // slave side: present the next source bit for the model's next sample
    always @(negedge clk)
        miso <= (rxq.size() < rxsrc.size()) ? rxsrc[rxq.size()] : 1'b0;

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            chk(sck == m_sck,    "R4/R5 sck per-cycle", {31'b0, sck}, {31'b0, m_sck});
            chk(mosi == m_mosi,  "R2/R5/R6 mosi per-cycle", {31'b0, mosi}, {31'b0, m_mosi});
            chk(done == m_done,  "R9 done per-cycle", {31'b0, done}, {31'b0, m_done});
            chk(perr == m_perr,  "R7/R8 perr per-cycle", {31'b0, perr}, {31'b0, m_perr});
            chk(rx_word == m_rx, "R9 rx_word per-cycle", rx_word, m_rx);
        end
    end

    // ---------------- directed frames ----------------
    task automatic run_frame(input logic [3:0] code, input bit lsb, input logic [2:0] dv,
                             input bit pol, input bit pha, input bit pen, input bit podd,
                             input bit txo, input logic [31:0] tx, input logic [31:0] pat,
                             input bit flip, input bit mid_start, input bit clr_hold);
        int n, cyc, nb;
        bit p;
        n = len_of(code);
        nb = n + (pen ? 1 : 0);
        rxsrc.delete();
        for (int i = 0; i < n; i++) rxsrc.push_back(lsb ? pat[i] : pat[n-1-i]);
        p = (^(pat & mask_of(n))) ^ podd ^ flip;
        if (pen) rxsrc.push_back(p);
        @(negedge clk);
        perr_clr = 1'b1;
        @(negedge clk);
        perr_clr = clr_hold;
        len_code = code; lsb_first = lsb; div_sel = dv; cpol = pol; cpha = pha;
        par_en = pen; par_odd = podd; tx_only = txo; tx_word = tx;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (mid_start && cyc == 3) begin
                start = 1'b1; tx_word = ~tx; len_code = 4'd15; cpol = ~pol;
                cpha = ~pha; lsb_first = ~lsb; div_sel = 3'd0;
            end
            if (mid_start && cyc == 4) begin
                start = 1'b0; tx_word = tx; len_code = code; cpol = pol;
                cpha = pha; lsb_first = lsb; div_sel = dv;
            end
        end
        perr_clr = 1'b0;
        chk(cyc == 2 * nb * (1 << dv) + 1, "R1/R3 start-to-done cycles", cyc, 2 * nb * (1 << dv) + 1);
        chk(rx_word == (pat & mask_of(n)), "R2/R9 received word", rx_word, pat & mask_of(n));
        chk(perr == (pen && !txo && flip), "R7/R8 parity flag after frame",
            {31'b0, perr}, {31'b0, pen && !txo && flip});
        if (mid_start) chk(cyc == 2 * nb * (1 << dv) + 1, "R10 mid-frame start ignored", cyc, 2 * nb * (1 << dv) + 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired act=%0d exp=%0d", 190000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sck == 1'b0 && mosi == 1'b0, "R4 reset pin levels", {30'b0, sck, mosi}, 32'h0);
        chk(done == 1'b0 && perr == 1'b0, "R9/R7 reset flags", {30'b0, done, perr}, 32'h0);
        chk(rx_word == '0, "R9 reset rx_word", rx_word, 32'h0);
        cpol = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(sck == 1'b1, "R4 idle level follows polarity", {31'b0, sck}, 32'h1);
        cmp_on = 1'b1;

        // R1 R2 R5: 8 bits, MSB first, phase 0, fastest clock, upper tx bits set
        run_frame(4'd4, 0, 3'd0, 0, 0, 0, 0, 0, 32'hFFFF_FFA5, 32'h0000_003C, 0, 0, 0);
        // R1 R2 R3: 4 bits, LSB first, phase 1, high idle, divide by 4
        run_frame(4'd0, 1, 3'd1, 1, 1, 0, 0, 0, 32'h0000_0009, 32'h0000_0006, 0, 0, 0);
        // R6: 16 bits, even parity, matching
        run_frame(4'd12, 0, 3'd2, 0, 1, 1, 0, 0, 32'h0000_BEEF, 32'h0000_1234, 0, 0, 0);
        // R7: 11 bits, odd parity, mismatching
        run_frame(4'd7, 1, 3'd0, 1, 0, 1, 1, 0, 32'h0000_05A3, 32'h0000_0671, 1, 0, 0);
        repeat (5) @(negedge clk);
        chk(perr == 1'b1, "R7 flag stays set while idle", {31'b0, perr}, 32'h1);
        perr_clr = 1'b1;
        @(negedge clk);
        perr_clr = 1'b0;
        chk(perr == 1'b0, "R7 clear drops flag", {31'b0, perr}, 32'h0);
        // R8: transmit-only with a bad parity bit
        run_frame(4'd8, 0, 3'd1, 0, 0, 1, 0, 1, 32'h0000_0ACE, 32'h0000_0F0F, 1, 0, 0);
        // R7: mismatch while clear is held: set wins
        run_frame(4'd5, 0, 3'd0, 0, 1, 1, 0, 0, 32'h0000_0033, 32'h0000_0015, 1, 0, 1);
        // R1: long frames
        run_frame(4'd13, 1, 3'd0, 0, 0, 0, 0, 0, 32'h000A_BCDE, 32'h0005_A5A5, 0, 0, 0);
        run_frame(4'd14, 0, 3'd1, 1, 1, 1, 1, 0, 32'h00C3_5A96, 32'h0012_3456, 0, 0, 0);
        run_frame(4'd15, 1, 3'd0, 0, 1, 1, 0, 0, 32'hDEAD_BEEF, 32'hF00D_CAFE, 0, 0, 0);
        run_frame(4'd15, 0, 3'd0, 1, 0, 0, 0, 0, 32'h8000_0001, 32'h8000_0001, 0, 0, 0);
        // R3: slowest divider
        run_frame(4'd0, 0, 3'd7, 0, 0, 0, 0, 0, 32'h0000_000B, 32'h0000_000D, 0, 0, 0);
        // R10: start and config changes during a frame
        run_frame(4'd4, 0, 3'd1, 0, 0, 1, 0, 0, 32'h0000_0096, 32'h0000_0069, 0, 1, 0);
        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule